// File: doc/BRIEF.md
# Two-Channel Sawtooth/Triangle PWM Timer

This block is a 16-bit waveform timer that drives two PWM pins, A and B. A prescaler turns the system clock into a count tick. The counter runs on that tick in one of two shapes. In sawtooth shape it counts in one direction and wraps at the programmed period. In triangle shape it rises to the period and then falls back to zero. The counter moves only while the `run` input is high. The cycle in which `run` rises is the start event, and the cycle in which it falls is the stop event.

Each pin keeps an internal level. The level changes when the counter leaves its own compare value or the period value, using a separately configured action for each of the two events. On start and stop the level either takes a programmed value or keeps its previous one. A brake input overrides the pin with a safe state chosen per channel, and an enable per pin can set the driver to high impedance. One-cycle pulses report overflow, underflow and each channel's compare match. All configuration inputs are expected to stay constant while the counter runs.

Top module: `pwm_wave_timer`

## Requirements
- R1: `prescale_sel` codes 0 to 7 give a tick divide of 1, 2, 4, 8, 16, 64, 256 and 1024. Let E0 be the clock edge that registers a start. The n-th count tick then falls on edge E(n·div). No tick occurs at E0.
- R2: Sawtooth up applies when `mode_sel` is neither 4 nor 5 and `dir_up`=1. On each tick the counter steps 0,1,…,P and then back to 0. `ovf_pulse` is high for one cycle after the tick that leaves P.
- R3: Sawtooth down applies when `mode_sel` is neither 4 nor 5 and `dir_up`=0. On each tick the counter steps down and reloads P after 0. `udf_pulse` is high for one cycle after each tick that leaves 0, including the first tick after reset.
- R4: Triangle applies when `mode_sel` is 4 or 5 and P ≥ 1. Starting from reset at 0 and rising, the count goes 0…P…0. Each turning value is held for one tick only. `ovf_pulse` follows the tick that leaves P. `udf_pulse` follows each tick that leaves 0, except the first tick after reset. The two pulses are never high together.
- R5: On a tick whose count before the tick equals a channel's compare value, that channel's `match` pulse is high for one cycle. At the same edge the channel's compare action is applied to its level. When the count before the tick equals P instead, the channel's period action is applied. Action codes: 0 = low, 1 = high, 2 = keep, 3 = invert. Each channel has its own pair of actions.
- R6: When the compare value equals P, so that both events fall on the same tick, only the compare action is applied.
- R7: With `ss_hold`=0, the level becomes `start_lvl` on the start edge and `stop_lvl` on the stop edge. With `ss_hold`=1, the level is kept on both edges. While `run` is low the count does not change.
- R8: While `brake_in` is high and the pin is enabled, the brake select for that pin takes effect in the same cycle: 0 = normal level, 1 = high impedance (oe low), 2 = driven low, 3 = driven high. The counter keeps counting during brake.
- R9: With `out_en` low the pin's oe is low, whatever the actions or brake. Whenever oe is low the pin data is 0.
- R10: After a synchronous reset the count is 0, the triangle direction is up, all pulses are 0 and both levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter runs while high; its rising edge is start and its falling edge is stop |
| prescale_sel | input | 3 | Tick divide code |
| mode_sel | input | 3 | 4 or 5 = triangle, otherwise sawtooth |
| dir_up | input | 1 | Sawtooth direction, 1 = up |
| period | input | 16 | Period value P |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| per_act_a | input | 2 | Period-match action, A |
| cmp_act_a | input | 2 | Compare-match action, A |
| per_act_b | input | 2 | Period-match action, B |
| cmp_act_b | input | 2 | Compare-match action, B |
| ss_hold_a | input | 1 | Keep level on start/stop, A |
| ss_hold_b | input | 1 | Keep level on start/stop, B |
| start_lvl_a | input | 1 | Start level, A |
| start_lvl_b | input | 1 | Start level, B |
| stop_lvl_a | input | 1 | Stop level, A |
| stop_lvl_b | input | 1 | Stop level, B |
| out_en_a | input | 1 | Pin driver enable, A |
| out_en_b | input | 1 | Pin driver enable, B |
| brake_in | input | 1 | Brake request |
| brake_sel_a | input | 2 | Brake state, A |
| brake_sel_b | input | 2 | Brake state, B |
| count | output | 16 | Counter value |
| pwm_a | output | 1 | Pin data, A |
| pwm_oe_a | output | 1 | Pin output enable, A |
| pwm_b | output | 1 | Pin data, B |
| pwm_oe_b | output | 1 | Pin output enable, B |
| ovf_pulse | output | 1 | Overflow / peak pulse |
| udf_pulse | output | 1 | Underflow / valley pulse |
| match_a | output | 1 | Compare-match pulse, A |
| match_b | output | 1 | Compare-match pulse, B |

## Verification
A period match and a compare match can fall on the same tick. The bench provokes this by setting one channel's compare value equal to the period, in every count shape and at several prescale settings. The bench judges the result with its own level model, where the compare action wins. The chosen actions pull opposite ways, so a wrong priority shows up directly on the pin. A second coincidence, the start or stop event against a count tick, cannot happen by design. The bench confirms this from the exact cycle of the first tick after start and from a frozen count after stop.

// File: rtl/pwm_wave_pkg.sv
package pwm_wave_pkg;

    localparam int MAX_SHIFT = 10;

    typedef enum logic [1:0] {
        ACT_LOW  = 2'd0,
        ACT_HIGH = 2'd1,
        ACT_KEEP = 2'd2,
        ACT_FLIP = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        BRK_RUN   = 2'd0,
        BRK_FLOAT = 2'd1,
        BRK_LOW   = 2'd2,
        BRK_HIGH  = 2'd3
    } brk_e;

    typedef struct packed {
        act_e per_act;
        act_e cmp_act;
        logic hold_ss;
        logic start_lvl;
        logic stop_lvl;
        logic out_en;
        brk_e brk;
    } chan_cfg_t;

    function automatic logic is_tri(input logic [2:0] m);
        return (m == 3'd4) || (m == 3'd5);
    endfunction

    function automatic logic [3:0] div_shift(input logic [2:0] code);
        case (code)
            3'd4:    return 4'd4;
            3'd5:    return 4'd6;
            3'd6:    return 4'd8;
            3'd7:    return 4'd10;
            default: return {1'b0, code};
        endcase
    endfunction

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_KEEP: return cur;
            default:  return ~cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic [2:0] sel,
    output logic       tick
);
    import pwm_wave_pkg::*;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = PRE_W'((32'd1 << div_shift(sel)) - 32'd1);
        tick = run_en && ((pre_cnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_wave_counter.sv
module pwm_wave_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             tri_en,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             udf
);
    logic             tri_up, tri_up_n;
    logic [CNT_W-1:0] cnt_n;
    logic             ovf_n, udf_n;

    always_comb begin
        cnt_n    = cnt;
        tri_up_n = tri_up;
        ovf_n    = 1'b0;
        udf_n    = 1'b0;
        if (tick) begin
            if (tri_en) begin
                if (tri_up) begin
                    if (cnt >= period) begin
                        ovf_n    = 1'b1;
                        tri_up_n = 1'b0;
                        cnt_n    = (period == '0) ? '0 : period - 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        udf_n    = 1'b1;
                        tri_up_n = 1'b1;
                        cnt_n    = (period == '0) ? '0 : CNT_W'(1);
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
            end else if (dir_up) begin
                if (cnt >= period) begin
                    ovf_n = 1'b1;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    udf_n = 1'b1;
                    cnt_n = period;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tri_up <= 1'b1;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            tri_up <= tri_up_n;
            ovf    <= ovf_n;
            udf    <= udf_n;
        end
    end
endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel #(
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   stop,
    input  logic                   tick,
    input  logic [CNT_W-1:0]       count,
    input  logic [CNT_W-1:0]       period,
    input  logic [CNT_W-1:0]       cmp,
    input  pwm_wave_pkg::chan_cfg_t cfg,
    input  logic                   brake_in,
    output logic                   pin,
    output logic                   oe,
    output logic                   match
);
    import pwm_wave_pkg::*;

    logic lvl;
    logic hit_c, hit_p;

    assign hit_c = tick && (count == cmp);
    assign hit_p = tick && (count == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl   <= 1'b0;
            match <= 1'b0;
        end else begin
            match <= hit_c;
            if (start)      lvl <= cfg.hold_ss ? lvl : cfg.start_lvl;
            else if (stop)  lvl <= cfg.hold_ss ? lvl : cfg.stop_lvl;
            else if (hit_c) lvl <= apply_act(cfg.cmp_act, lvl);
            else if (hit_p) lvl <= apply_act(cfg.per_act, lvl);
        end
    end

    always_comb begin
        oe  = 1'b1;
        pin = lvl;
        if (!cfg.out_en) begin
            oe  = 1'b0;
            pin = 1'b0;
        end else if (brake_in) begin
            case (cfg.brk)
                BRK_FLOAT: begin oe = 1'b0; pin = 1'b0; end
                BRK_LOW:   pin = 1'b0;
                BRK_HIGH:  pin = 1'b1;
                default:   pin = lvl;
            endcase
        end
    end
endmodule

// File: rtl/pwm_wave_timer.sv
module pwm_wave_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [2:0]       prescale_sel,
    input  logic [2:0]       mode_sel,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [1:0]       per_act_a,
    input  logic [1:0]       cmp_act_a,
    input  logic [1:0]       per_act_b,
    input  logic [1:0]       cmp_act_b,
    input  logic             ss_hold_a,
    input  logic             ss_hold_b,
    input  logic             start_lvl_a,
    input  logic             start_lvl_b,
    input  logic             stop_lvl_a,
    input  logic             stop_lvl_b,
    input  logic             out_en_a,
    input  logic             out_en_b,
    input  logic             brake_in,
    input  logic [1:0]       brake_sel_a,
    input  logic [1:0]       brake_sel_b,
    output logic [CNT_W-1:0] count,
    output logic             pwm_a,
    output logic             pwm_oe_a,
    output logic             pwm_b,
    output logic             pwm_oe_b,
    output logic             ovf_pulse,
    output logic             udf_pulse,
    output logic             match_a,
    output logic             match_b
);
    import pwm_wave_pkg::*;

    localparam int PRE_W = MAX_SHIFT;
    localparam int N_CH  = 2;

    logic run_q, start_ev, stop_ev, run_en, tick;
    chan_cfg_t        cfg_v [N_CH];
    logic [CNT_W-1:0] cmp_v [N_CH];
    logic             pin_v [N_CH];
    logic             oe_v  [N_CH];
    logic             hit_v [N_CH];

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= run;
    end

    assign start_ev = run & ~run_q;
    assign stop_ev  = ~run & run_q;
    assign run_en   = run & run_q;

    always_comb begin
        cfg_v[0].per_act   = act_e'(per_act_a);
        cfg_v[0].cmp_act   = act_e'(cmp_act_a);
        cfg_v[0].hold_ss   = ss_hold_a;
        cfg_v[0].start_lvl = start_lvl_a;
        cfg_v[0].stop_lvl  = stop_lvl_a;
        cfg_v[0].out_en    = out_en_a;
        cfg_v[0].brk       = brk_e'(brake_sel_a);
        cfg_v[1].per_act   = act_e'(per_act_b);
        cfg_v[1].cmp_act   = act_e'(cmp_act_b);
        cfg_v[1].hold_ss   = ss_hold_b;
        cfg_v[1].start_lvl = start_lvl_b;
        cfg_v[1].stop_lvl  = stop_lvl_b;
        cfg_v[1].out_en    = out_en_b;
        cfg_v[1].brk       = brk_e'(brake_sel_b);
        cmp_v[0] = cmp_a;
        cmp_v[1] = cmp_b;
    end

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run_en(run_en), .sel(prescale_sel), .tick(tick)
    );

    pwm_wave_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .tri_en(is_tri(mode_sel)),
        .dir_up(dir_up), .period(period), .cnt(count),
        .ovf(ovf_pulse), .udf(udf_pulse)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_out_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .start(start_ev), .stop(stop_ev),
            .tick(tick), .count(count), .period(period), .cmp(cmp_v[i]),
            .cfg(cfg_v[i]), .brake_in(brake_in),
            .pin(pin_v[i]), .oe(oe_v[i]), .match(hit_v[i])
        );
    end

    assign pwm_a    = pin_v[0];
    assign pwm_oe_a = oe_v[0];
    assign pwm_b    = pin_v[1];
    assign pwm_oe_b = oe_v[1];
    assign match_a  = hit_v[0];
    assign match_b  = hit_v[1];
endmodule

// File: rtl/pwm_wave_timer_chk.sv
module pwm_wave_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [2:0]       prescale_sel,
    input logic [2:0]       mode_sel,
    input logic             dir_up,
    input logic [CNT_W-1:0] period,
    input logic [1:0]       cmp_act_a,
    input logic             out_en_a,
    input logic             out_en_b,
    input logic             brake_in,
    input logic [1:0]       brake_sel_a,
    input logic [CNT_W-1:0] count,
    input logic             pwm_a,
    input logic             pwm_oe_a,
    input logic             pwm_b,
    input logic             pwm_oe_b,
    input logic             ovf_pulse,
    input logic             udf_pulse,
    input logic             match_a
);
    logic tri_m;
    assign tri_m = (mode_sel == 3'd4) || (mode_sel == 3'd5);

    p_saw_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && prescale_sel == 3'd0 && !tri_m && dir_up && count < period)
        |=> count == $past(count) + 1'b1);

    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && !$past(tri_m)) |-> count == '0);

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (udf_pulse && !$past(tri_m)) |-> count == $past(period));

    p_peak_turn_r4: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && $past(tri_m) && $past(period) != '0) |-> count == $past(period) - 1'b1);

    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(ovf_pulse && udf_pulse));

    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (match_a && !$past(rst) && $past(cmp_act_a) == 2'd2 && !brake_in && !$past(brake_in)
         && out_en_a && $past(out_en_a)) |-> pwm_a == $past(pwm_a));

    p_invert_r5: assert property (@(posedge clk) disable iff (rst)
        (match_a && !$past(rst) && $past(cmp_act_a) == 2'd3 && !brake_in && !$past(brake_in)
         && out_en_a && $past(out_en_a)) |-> pwm_a != $past(pwm_a));

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    p_brake_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (brake_in && out_en_a && brake_sel_a == 2'd3) |-> (pwm_oe_a && pwm_a));

    p_brake_float_r8: assert property (@(posedge clk) disable iff (rst)
        (brake_in && out_en_a && brake_sel_a == 2'd1) |-> (!pwm_oe_a && !pwm_a));

    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
        !out_en_b |-> (!pwm_oe_b && !pwm_b));
endmodule

bind pwm_wave_timer pwm_wave_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .prescale_sel(prescale_sel),
    .mode_sel(mode_sel), .dir_up(dir_up), .period(period),
    .cmp_act_a(cmp_act_a), .out_en_a(out_en_a), .out_en_b(out_en_b),
    .brake_in(brake_in), .brake_sel_a(brake_sel_a), .count(count),
    .pwm_a(pwm_a), .pwm_oe_a(pwm_oe_a), .pwm_b(pwm_b), .pwm_oe_b(pwm_oe_b),
    .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .match_a(match_a)
);

// File: tb/sim_pwm_wave_timer.sv
module sim_pwm_wave_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [2:0]  prescale_sel = '0, mode_sel = '0;
    logic        dir_up = 1'b1;
    logic [15:0] period = 16'd3, cmp_a = '0, cmp_b = '0;
    logic [1:0]  per_act_a = '0, cmp_act_a = '0, per_act_b = '0, cmp_act_b = '0;
    logic        ss_hold_a = 0, ss_hold_b = 0, start_lvl_a = 0, start_lvl_b = 0;
    logic        stop_lvl_a = 0, stop_lvl_b = 0, out_en_a = 1, out_en_b = 1;
    logic        brake_in = 0;
    logic [1:0]  brake_sel_a = '0, brake_sel_b = '0;
    logic [15:0] count;
    logic        pwm_a, pwm_oe_a, pwm_b, pwm_oe_b, ovf_pulse, udf_pulse, match_a, match_b;

    int nvec = 0, nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_wave_timer u0 (
        .clk(clk), .rst(rst), .run(run), .prescale_sel(prescale_sel), .mode_sel(mode_sel),
        .dir_up(dir_up), .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .per_act_a(per_act_a), .cmp_act_a(cmp_act_a), .per_act_b(per_act_b), .cmp_act_b(cmp_act_b),
        .ss_hold_a(ss_hold_a), .ss_hold_b(ss_hold_b), .start_lvl_a(start_lvl_a), .start_lvl_b(start_lvl_b),
        .stop_lvl_a(stop_lvl_a), .stop_lvl_b(stop_lvl_b), .out_en_a(out_en_a), .out_en_b(out_en_b),
        .brake_in(brake_in), .brake_sel_a(brake_sel_a), .brake_sel_b(brake_sel_b),
        .count(count), .pwm_a(pwm_a), .pwm_oe_a(pwm_oe_a), .pwm_b(pwm_b), .pwm_oe_b(pwm_oe_b),
        .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .match_a(match_a), .match_b(match_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int div_of(input int code);
        case (code)
            4: return 16;
            5: return 64;
            6: return 256;
            7: return 1024;
            default: return 1 << code;
        endcase
    endfunction

    function automatic int cnt_at(input bit tri_m, input bit up, input int p, input int t);
        int q;
        if (tri_m) begin
            q = t % (2 * p);
            return (q <= p) ? q : 2 * p - q;
        end
        if (up) return t % (p + 1);
        return ((p + 1) - (t % (p + 1))) % (p + 1);
    endfunction

    function automatic bit act(input int code, input bit cur);
        case (code)
            0: return 1'b0;
            1: return 1'b1;
            2: return cur;
            default: return ~cur;
        endcase
    endfunction

    task automatic do_reset();
        run = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic run_case(input int msel, input bit up, input int psel, input int p, input int ncyc);
        bit tri_m, la, lb, tk, eo, eu;
        int dv, t, pc, tl;
        string rq;
        mode_sel = 3'(msel); dir_up = up; prescale_sel = 3'(psel); period = 16'(p);
        tri_m = (msel == 4) || (msel == 5);
        rq = tri_m ? "R4" : (up ? "R2" : "R3");
        if (psel != 0) rq = {"R1 ", rq};
        dv = div_of(psel);
        do_reset();
        run = 1;
        la = ss_hold_a ? 1'b0 : start_lvl_a;   // R7 start level
        lb = ss_hold_b ? 1'b0 : start_lvl_b;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            t  = n / dv;
            tk = (n > 0) && (n % dv == 0);
            eo = 0; eu = 0; pc = -1;
            if (tk) begin
                pc = cnt_at(tri_m, up, p, t - 1);
                if (tri_m) begin
                    eo = ((t - 1) % (2 * p)) == p;
                    eu = (((t - 1) % (2 * p)) == 0) && (t - 1 != 0);
                end else if (up) eo = (pc == p);
                else eu = (pc == 0);
                if (pc == int'(cmp_a)) la = act(int'(cmp_act_a), la);      // R6 compare first
                else if (pc == p)      la = act(int'(per_act_a), la);
                if (pc == int'(cmp_b)) lb = act(int'(cmp_act_b), lb);
                else if (pc == p)      lb = act(int'(per_act_b), lb);
            end
            chk({rq, " count"}, int'(count), cnt_at(tri_m, up, p, t));
            chk({rq, " ovf"}, int'(ovf_pulse), int'(eo));
            chk({rq, " udf"}, int'(udf_pulse), int'(eu));
            chk("R5 match_a", int'(match_a), int'(tk && pc == int'(cmp_a)));
            chk("R5 match_b", int'(match_b), int'(tk && pc == int'(cmp_b)));
            chk("R5 R6 R7 pwm_a", int'(pwm_a), int'(la));
            chk("R5 R6 R7 pwm_b", int'(pwm_b), int'(lb));
        end
        tl = (ncyc - 1) / dv;
        run = 0;
        if (!ss_hold_a) la = stop_lvl_a;
        if (!ss_hold_b) lb = stop_lvl_b;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 frozen count", int'(count), cnt_at(tri_m, up, p, tl));
            chk("R7 stop pwm_a", int'(pwm_a), int'(la));
            chk("R7 stop pwm_b", int'(pwm_b), int'(lb));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int c0;
        int ms [5] = '{0, 0, 4, 5, 2};
        bit ud [5] = '{1, 0, 1, 1, 1};
        int ps [3] = '{1, 3, 6};
        // R10 reset state
        do_reset();
        @(negedge clk);
        chk("R10 count", int'(count), 0);
        chk("R10 ovf", int'(ovf_pulse), 0);
        chk("R10 udf", int'(udf_pulse), 0);
        chk("R10 match_a", int'(match_a), 0);
        chk("R10 pwm_a", int'(pwm_a), 0);
        chk("R10 oe_a", int'(pwm_oe_a), 1);

        // shapes x prescale x period x two action sets
        for (int m = 0; m < 5; m++)
            for (int psel = 0; psel < 3; psel++)
                for (int pi = 0; pi < 3; pi++)
                    for (int s = 0; s < 2; s++) begin
                        if (s == 0) begin
                            cmp_a = 16'd1; cmp_b = 16'(ps[pi]);     // B: compare on period (R6)
                            per_act_a = 2'd0; cmp_act_a = 2'd1;
                            per_act_b = 2'd1; cmp_act_b = 2'd0;
                            ss_hold_a = 0; ss_hold_b = 0;
                            start_lvl_a = 1; start_lvl_b = 0; stop_lvl_a = 0; stop_lvl_b = 1;
                        end else begin
                            cmp_a = 16'(ps[pi] / 2); cmp_b = 16'd0;
                            per_act_a = 2'd3; cmp_act_a = 2'd2;
                            per_act_b = 2'd2; cmp_act_b = 2'd3;
                            ss_hold_a = 1; ss_hold_b = 1;
                            start_lvl_a = 1; start_lvl_b = 1; stop_lvl_a = 0; stop_lvl_b = 0;
                        end
                        run_case(ms[m], ud[m], psel, ps[pi], (2 * ps[pi] + 2) * div_of(psel) * 2);
                    end

        // R1 every divide code, first ticks
        for (int psel = 0; psel < 8; psel++)
            run_case(0, 1'b1, psel, 3, 2 * div_of(psel) + 2);

        // R8 / R9 pin stage
        per_act_a = 2'd2; cmp_act_a = 2'd2; per_act_b = 2'd2; cmp_act_b = 2'd2;
        ss_hold_a = 0; ss_hold_b = 0; start_lvl_a = 1; start_lvl_b = 0;
        mode_sel = 3'd0; dir_up = 1; prescale_sel = 3'd0; period = 16'd100;
        do_reset();
        run = 1;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            brake_sel_a = 2'(b); brake_sel_b = 2'(b); brake_in = 1;
            #1;
            chk("R8 oe_a", int'(pwm_oe_a), (b == 1) ? 0 : 1);
            chk("R8 pwm_a", int'(pwm_a), (b == 0 || b == 3) ? 1 : 0);
            chk("R8 oe_b", int'(pwm_oe_b), (b == 1) ? 0 : 1);
            chk("R8 pwm_b", int'(pwm_b), (b == 3) ? 1 : 0);
            c0 = int'(count);
            @(negedge clk);
            chk("R8 counts under brake", int'(count), c0 + 1);
        end
        out_en_a = 0;
        for (int b = 0; b < 4; b++) begin
            brake_sel_a = 2'(b); brake_in = b[0];
            #1;
            chk("R9 oe_a off", int'(pwm_oe_a), 0);
            chk("R9 pwm_a off", int'(pwm_a), 0);
        end
        out_en_a = 1; brake_in = 0;
        #1;
        chk("R9 oe_a restored", int'(pwm_oe_a), 1);
        chk("R9 pwm_a restored", int'(pwm_a), 1);
        run = 0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule